// File: doc/BRIEF.md
# Gather Copy Descriptor Sequencer

This block sits at the front of a copy engine. It takes in 128-bit source descriptors one at a time over a valid/ready handshake. Each descriptor holds a 40-bit source pointer, a 16-bit byte length, a few per-transfer controls and a 16-bit metadata tag. From each descriptor with a nonzero length the block issues one read command. The pointer is split into a routed bus address (the low 37 bits by default), a group of user bits, and a virtual-channel select bit, which is the topmost pointer bit.

Descriptors can be chained so that several source buffers feed one destination. A descriptor whose chain flag is set keeps the current copy cycle open. The first descriptor with the flag clear closes the cycle, and the block then pulses a completion strobe carrying the cycle's total byte count. The hash enable, the two byte-swap controls and the metadata are captured only from the descriptor that opens a cycle. They stay fixed until the cycle closes. The two swap controls drive byte-reversal stages on the read-data and write-data paths.

Top module: `gather_desc_seq`

## Requirements
- R1: Descriptor word k sits at bits [32k+31:32k] of `desc_data`. The pointer is bits [39:0] (word 0, plus word 1 bits [7:0] as bits 39:32). The command carries the pointer's low ADDR_W bits as `rd_addr` and the remaining upper bits as `rd_user`. `rd_vc` equals pointer bit 39, `rd_len` equals word 1 bits [31:16], and `rd_barrier` equals word 1 bit 13.
- R2: A descriptor accepted with a nonzero length raises `rd_valid` at the next clock edge. While `rd_ready` is low, the command stays valid and all of its fields stay unchanged.
- R3: `desc_ready` is low exactly when a read command is pending and `rd_ready` is low. No descriptor is taken in that state.
- R4: An accepted descriptor with zero length issues no read command. It still takes part in chaining and in the byte count.
- R5: The descriptor that opens a cycle sets `cyc_hash_en` (word 1 bit 8), `cyc_src_swap` (bit 9), `cyc_dst_swap` (bit 10) and `cyc_meta` (word 2 bits [15:0]) at the edge that accepts it. Later descriptors in the same cycle leave these outputs unchanged.
- R6: Word 1 bit 11 set means the cycle continues. An accepted descriptor with that bit clear produces a one-cycle `done_valid` after the accepting edge. `done_bytes` then equals the sum of the lengths of the cycle's descriptors, modulo 2^CNT_W. No pulse occurs otherwise.
- R7: With `cyc_src_swap` high, `rdat_out` is `rdat_in` with byte 0 exchanged with byte 3 and byte 1 exchanged with byte 2. With it low, `rdat_out` equals `rdat_in`.
- R8: `wdat_out` follows the same rule as R7, driven from `wdat_in` and `cyc_dst_swap`.
- R9: Word 1 bits 12 and [15:14], word 2 bits [31:16] and all of word 3 have no effect on any output.
- R10: After reset, `rd_valid` and `done_valid` are low, and all cycle controls and `cyc_meta` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_data | input | 128 | Four descriptor words |
| rd_valid | output | 1 | Read command pending |
| rd_ready | input | 1 | Read command consumed |
| rd_addr | output | ADDR_W | Routed source address |
| rd_user | output | 40-ADDR_W | Upper pointer bits passed as user bits |
| rd_vc | output | 1 | Virtual channel select |
| rd_len | output | 16 | Read length in bytes |
| rd_barrier | output | 1 | Barrier read request |
| cyc_hash_en | output | 1 | Hash enable of the current cycle |
| cyc_src_swap | output | 1 | Read-data swap of the current cycle |
| cyc_dst_swap | output | 1 | Write-data swap of the current cycle |
| cyc_meta | output | 16 | Metadata of the current cycle |
| done_valid | output | 1 | Cycle completion pulse |
| done_bytes | output | CNT_W | Byte total of the completed cycle |
| rdat_in | input | 32 | Read data from memory |
| rdat_out | output | 32 | Read data after optional swap |
| wdat_in | input | 32 | Write data toward destination |
| wdat_out | output | 32 | Write data after optional swap |

## Verification
The bench uses the default parameters, ADDR_W=37 and CNT_W=24. The 37-bit routed address leaves a 3-bit user field whose top bit is the channel select, so a single all-ones pointer shows the address, user and channel fields separating cleanly. The 24-bit counter holds a chain of two maximum-length buffers plus a short tail (0x20000 bytes) without wrapping. That makes the exact byte total observable. Zero-length links, reserved bits set to ones inside a chain, and a stalled command with a waiting descriptor are all reached within short directed sequences.

// File: rtl/gds_pkg.sv
package gds_pkg;
  localparam int PTR_W    = 40;
  localparam int LEN_W    = 16;
  localparam int META_W   = 16;
  localparam int POS_HASH = 40;
  localparam int POS_SSW  = 41;
  localparam int POS_DSW  = 42;
  localparam int POS_CHN  = 43;
  localparam int POS_BAR  = 45;
  localparam int POS_LEN  = 48;
  localparam int POS_META = 64;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr;
    logic [LEN_W-1:0]  len;
    logic              hash_en;
    logic              src_sw;
    logic              dst_sw;
    logic              chain;
    logic              barrier;
    logic [META_W-1:0] meta;
  } dfield_t;

  function automatic dfield_t unpack_desc(input logic [127:0] d);
    dfield_t f;
    f.ptr     = d[PTR_W-1:0];
    f.len     = d[POS_LEN +: LEN_W];
    f.hash_en = d[POS_HASH];
    f.src_sw  = d[POS_SSW];
    f.dst_sw  = d[POS_DSW];
    f.chain   = d[POS_CHN];
    f.barrier = d[POS_BAR];
    f.meta    = d[POS_META +: META_W];
    return f;
  endfunction
endpackage

// File: rtl/gds_swap.sv
module gds_swap #(
  parameter int LANES = 4
) (
  input  logic               en,
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  logic [8*LANES-1:0] rev;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rev[8*i +: 8] = din[8*(LANES-1-i) +: 8];
  end

  assign dout = en ? rev : din;

  // R7 and R8: lowest output byte comes from the top input byte when enabled
  always_comb begin
    if (en) begin
      p_swap_ends_r7: assert (dout[7:0] == din[8*LANES-1 -: 8]);
    end
  end
endmodule

// File: rtl/gds_rdcmd.sv
module gds_rdcmd
  import gds_pkg::*;
#(
  parameter int ADDR_W = 37,
  localparam int USER_W = PTR_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  dfield_t           f,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [USER_W-1:0] rd_user,
  output logic              rd_vc,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_barrier,
  output logic              stall
);
  logic issue_evt;
  assign issue_evt = load && (f.len != '0);
  assign stall     = rd_valid && !rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_addr    <= '0;
      rd_user    <= '0;
      rd_vc      <= 1'b0;
      rd_len     <= '0;
      rd_barrier <= 1'b0;
    end else if (issue_evt) begin
      rd_valid   <= 1'b1;
      rd_addr    <= f.ptr[ADDR_W-1:0];
      rd_user    <= f.ptr[PTR_W-1:ADDR_W];
      rd_vc      <= f.ptr[PTR_W-1];
      rd_len     <= f.len;
      rd_barrier <= f.barrier;
    end else if (rd_ready) begin
      rd_valid   <= 1'b0;
    end
  end

  p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> rd_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> rd_valid && $stable(rd_addr) && $stable(rd_len) && $stable(rd_user));
  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && f.len == '0) |=> !rd_valid);
endmodule

// File: rtl/gds_chain.sv
module gds_chain
  import gds_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  dfield_t           f,
  output logic              hash_en,
  output logic              src_sw,
  output logic              dst_sw,
  output logic [META_W-1:0] meta,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_bytes
);
  logic             cyc_open;
  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] sum;
  logic             open_evt;
  logic             close_evt;

  assign base      = cyc_open ? acc : '0;
  assign sum       = base + CNT_W'(f.len);
  assign open_evt  = load && !cyc_open;
  assign close_evt = load && !f.chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_open   <= 1'b0;
      acc        <= '0;
      hash_en    <= 1'b0;
      src_sw     <= 1'b0;
      dst_sw     <= 1'b0;
      meta       <= '0;
      done_valid <= 1'b0;
      done_bytes <= '0;
    end else begin
      done_valid <= close_evt;
      if (open_evt) begin
        hash_en <= f.hash_en;
        src_sw  <= f.src_sw;
        dst_sw  <= f.dst_sw;
        meta    <= f.meta;
      end
      if (load) begin
        cyc_open <= f.chain;
        acc      <= sum;
      end
      if (close_evt) done_bytes <= sum;
    end
  end

  p_ctrl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cyc_open) |=> $stable({hash_en, src_sw, dst_sw, meta}));
  p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> done_valid);
  p_done_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> !done_valid && $stable(done_bytes));
endmodule

// File: rtl/gather_desc_seq.sv
module gather_desc_seq
  import gds_pkg::*;
#(
  parameter int ADDR_W = 37,
  parameter int CNT_W  = 24,
  localparam int USER_W = PTR_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [127:0]      desc_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [USER_W-1:0] rd_user,
  output logic              rd_vc,
  output logic [LEN_W-1:0]  rd_len,
  output logic              rd_barrier,
  output logic              cyc_hash_en,
  output logic              cyc_src_swap,
  output logic              cyc_dst_swap,
  output logic [META_W-1:0] cyc_meta,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_bytes,
  input  logic [31:0]       rdat_in,
  output logic [31:0]       rdat_out,
  input  logic [31:0]       wdat_in,
  output logic [31:0]       wdat_out
);
  dfield_t fld;
  logic    cmd_stall;
  logic    accept_evt;

  assign fld        = unpack_desc(desc_data);
  assign desc_ready = !cmd_stall;
  assign accept_evt = desc_valid && desc_ready;

  gds_rdcmd #(.ADDR_W(ADDR_W)) u_rdcmd (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .f(fld),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_user(rd_user), .rd_vc(rd_vc), .rd_len(rd_len),
    .rd_barrier(rd_barrier), .stall(cmd_stall)
  );

  gds_chain #(.CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .load(accept_evt), .f(fld),
    .hash_en(cyc_hash_en), .src_sw(cyc_src_swap), .dst_sw(cyc_dst_swap),
    .meta(cyc_meta), .done_valid(done_valid), .done_bytes(done_bytes)
  );

  gds_swap #(.LANES(4)) u_rswap (.en(cyc_src_swap), .din(rdat_in), .dout(rdat_out));
  gds_swap #(.LANES(4)) u_wswap (.en(cyc_dst_swap), .din(wdat_in), .dout(wdat_out));

  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && fld.len != '0) |=>
      rd_addr == $past(desc_data[ADDR_W-1:0]) && rd_vc == $past(desc_data[PTR_W-1]));
  p_back_press_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> rd_valid);
endmodule

// File: tb/gather_desc_seq_tb.sv
module gather_desc_seq_tb;
  localparam int AW = 37;
  localparam int CW = 24;

  typedef struct packed {
    logic [31:0] w0, w1, w2, w3;
    logic        rd;
    logic        dn;
    logic [23:0] bytes;
    logic [2:0]  ctl;   // {hash, src swap, dst swap}
    logic [15:0] meta;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h12345678, 32'h001003AB, 32'h00001111, 32'h0, 1'b1, 1'b1, 24'h10,    3'b110, 16'h1111},
    '{32'h00000040, 32'h01002C05, 32'h00002222, 32'h0, 1'b1, 1'b0, 24'h0,     3'b001, 16'h2222},
    '{32'h00000000, 32'h0000DB00, 32'hFFFF3333, 32'hFFFFFFFF, 1'b0, 1'b0, 24'h0, 3'b001, 16'h2222},
    '{32'h00001000, 32'h00200200, 32'h00004444, 32'hFFFFFFFF, 1'b1, 1'b1, 24'h120, 3'b001, 16'h2222},
    '{32'h00000000, 32'h00000000, 32'h00005555, 32'h0, 1'b0, 1'b1, 24'h0,     3'b000, 16'h5555},
    '{32'hFFFFFFFF, 32'hFFFF08FF, 32'h00006666, 32'h0, 1'b1, 1'b0, 24'h0,     3'b000, 16'h6666},
    '{32'h00000000, 32'hFFFF0F00, 32'h0000ABCD, 32'h0, 1'b1, 1'b0, 24'h0,     3'b000, 16'h6666},
    '{32'h00000010, 32'h00020000, 32'h00000000, 32'h0, 1'b1, 1'b1, 24'h20000, 3'b000, 16'h6666}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 1'b0, rd_ready = 1'b1;
  logic [127:0] desc_data = '0;
  logic desc_ready, rd_valid, rd_vc, rd_barrier;
  logic [AW-1:0] rd_addr;
  logic [39-AW:0] rd_user;
  logic [15:0] rd_len, cyc_meta;
  logic cyc_hash_en, cyc_src_swap, cyc_dst_swap, done_valid;
  logic [CW-1:0] done_bytes;
  logic [31:0] rdat_in = '0, wdat_in = '0, rdat_out, wdat_out;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  gather_desc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_data(desc_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_user(rd_user), .rd_vc(rd_vc), .rd_len(rd_len),
    .rd_barrier(rd_barrier), .cyc_hash_en(cyc_hash_en), .cyc_src_swap(cyc_src_swap),
    .cyc_dst_swap(cyc_dst_swap), .cyc_meta(cyc_meta), .done_valid(done_valid),
    .done_bytes(done_bytes), .rdat_in(rdat_in), .rdat_out(rdat_out),
    .wdat_in(wdat_in), .wdat_out(wdat_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w0, w1, w2, w3);
    @(negedge clk);
    desc_valid = 1'b1;
    desc_data  = {w3, w2, w1, w0};
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  function automatic logic [31:0] brev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rd_valid", {63'b0, rd_valid}, 64'd0);
    chk("R10 done_valid", {63'b0, done_valid}, 64'd0);
    chk("R10 controls", {45'b0, cyc_hash_en, cyc_src_swap, cyc_dst_swap, cyc_meta}, 64'd0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      logic [39:0] p;
      send(VEC[i].w0, VEC[i].w1, VEC[i].w2, VEC[i].w3);
      p = {VEC[i].w1[7:0], VEC[i].w0};
      chk("R2/R4 rd_valid", {63'b0, rd_valid}, {63'b0, VEC[i].rd});
      if (VEC[i].rd) begin
        chk("R1 addr", {27'b0, rd_addr}, {27'b0, p[36:0]});
        chk("R1 user vc", {60'b0, rd_user, rd_vc}, {60'b0, p[39:37], VEC[i].w1[7]});
        chk("R1 len barrier", {47'b0, rd_len, rd_barrier}, {47'b0, VEC[i].w1[31:16], VEC[i].w1[13]});
      end
      chk("R5 R9 controls", {61'b0, cyc_hash_en, cyc_src_swap, cyc_dst_swap}, {61'b0, VEC[i].ctl});
      chk("R5 R9 meta", {48'b0, cyc_meta}, {48'b0, VEC[i].meta});
      chk("R6 done_valid", {63'b0, done_valid}, {63'b0, VEC[i].dn});
      if (VEC[i].dn) chk("R6 done_bytes", {40'b0, done_bytes}, {40'b0, VEC[i].bytes});
      @(negedge clk);
      chk("R6 pulse width", {63'b0, done_valid}, 64'd0);
    end

    // R7 R8: both swaps on
    send(32'h0, 32'h00040600, 32'h0, 32'h0);
    rdat_in = 32'h11223344; wdat_in = 32'hAABBCCDD; #1;
    chk("R7 read swap", {32'b0, rdat_out}, {32'b0, brev(32'h11223344)});
    chk("R8 write swap", {32'b0, wdat_out}, {32'b0, brev(32'hAABBCCDD)});
    // source swap only
    send(32'h0, 32'h00040200, 32'h0, 32'h0);
    #1;
    chk("R7 read swap only", {32'b0, rdat_out}, {32'b0, 32'h44332211});
    chk("R8 write pass", {32'b0, wdat_out}, {32'b0, 32'hAABBCCDD});
    send(32'h0, 32'h00040000, 32'h0, 32'h0);
    #1;
    chk("R7 read pass", {32'b0, rdat_out}, {32'b0, 32'h11223344});

    // R2 R3: back-pressure
    @(negedge clk);
    rd_ready = 1'b0; desc_valid = 1'b1;
    desc_data = {32'h0, 32'h0, 32'h00080000, 32'h00000100};
    @(negedge clk);
    chk("R2 stalled valid", {63'b0, rd_valid}, 64'd1);
    chk("R3 ready low", {63'b0, desc_ready}, 64'd0);
    desc_data = {32'h0, 32'h0, 32'h00080000, 32'h00000200};
    @(negedge clk); @(negedge clk);
    chk("R2 addr held", {27'b0, rd_addr}, 64'h100);
    chk("R3 still blocked", {63'b0, desc_ready}, 64'd0);
    rd_ready = 1'b1; #1;
    chk("R3 ready on consume", {63'b0, desc_ready}, 64'd1);
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R2 next cmd", {27'b0, rd_addr}, 64'h200);
    @(negedge clk);
    chk("R2 drained", {63'b0, rd_valid}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule